// File: doc/BRIEF.md
# Free-Running Tick Timer with One Compare Channel

This block is a small system timer that sits on a plain 32-bit register bus with separate read and write strobes. It holds a 64-bit counter that advances by one on every clock and never stops. Software reads the counter as two 32-bit words, low and high. Neither word is captured at the moment the other one is read.

One compare channel watches only the low 32 bits of the count. Software loads a target, computed modulo 2^32, and sets the enable bit. When the low word reaches the target, a sticky match flag is set and a level interrupt goes high. This gives one-shot tick events. The interrupt handler disables the channel and clears the flag with a single read-modify-write of the status word. It then loads the next target and enables the channel again.

Because the words are read separately, a carry out of the low word can fall between two reads. Software detects this by reading high, then low, then high again, and repeating until both high reads agree.

Top module: `stc_tick_timer`

## Requirements
- R1: After reset, the counter, the compare value, the enable bit, the match flag, the read data and the interrupt are all zero.
- R2: The counter increases by exactly one on every clock after reset. A read at offset 0x04 returns count[31:0] and a read at offset 0x08 returns count[63:32], both as they stood at the clock edge that samples the read strobe.
- R3: Writes to offsets 0x04 and 0x08 have no effect on the counter.
- R4: Offset 0x0C holds a 32-bit compare value. It reads back exactly what was last written.
- R5: At offset 0x00 (control/status), bit 4 is the compare enable and is an ordinary read/write bit. Bits 1-3 and 5-31 always read as zero.
- R6: While the enable is 1 and count[31:0] equals the compare value at a clock edge, the match flag (bit 0 of offset 0x00) is 1 from that edge on.
- R7: While the enable is 0, the match flag is never set, whatever the count.
- R8: Once set, the match flag stays set, even after the enable is cleared. Only a write to offset 0x00 with bit 0 = 1 clears it; a write with bit 0 = 0 leaves it unchanged.
- R9: If a match and a clearing write to bit 0 happen at the same edge, the flag ends up set.
- R10: The interrupt output equals (match flag AND enable) in every cycle, as a level.
- R11: Read data appears one cycle after the read strobe and is zero in cycles with no read. Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| irq | output | 1 | Level interrupt: match flag AND compare enable |

## Verification
The bench targets the edge where a match and a clearing write coincide. A design that gives the clear priority would lose that tick, and the flag would read as 0. It drops the enable while the flag is set. A design that clears the flag along with the enable, or leaves the interrupt high, is caught on the next status read and by the per-cycle interrupt check. It writes to the counter offsets, writes all-ones patterns to the status word, and reads unmapped offsets, so any writable counter, any stray status bit, or a read mux with no default would show up as a wrong read value. Random reads and writes are compared against a cycle-accurate bench model throughout. A match flag that fires while the enable is off, or on the wrong cycle, fails there.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FLAG_POS = 0;
  localparam int unsigned ENA_POS  = 4;

  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_CNT_LO = 'h04;
  localparam int unsigned OFS_CNT_HI = 'h08;
  localparam int unsigned OFS_CMP    = 'h0C;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_CMP,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/stc_counter.sv
module stc_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count = cnt_q;

  // R2: one step per clock, never held or cleared outside reset
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/stc_compare.sv
module stc_compare #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cnt_lo,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] cmp_wdata,
  input  logic              ctl_we,
  input  logic              ctl_en_wr,
  input  logic              ctl_clr_wr,
  output logic [DATA_W-1:0] cmp_q,
  output logic              en_q,
  output logic              flag_q,
  output logic              irq_q
);
  logic hit;
  logic clr;
  logic flag_d;
  logic en_d;

  always_comb begin
    hit    = en_q && (cnt_lo == cmp_q);
    clr    = ctl_we && ctl_clr_wr;
    flag_d = hit || (flag_q && !clr);
    en_d   = ctl_we ? ctl_en_wr : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= cmp_wdata;
      en_q   <= en_d;
      flag_q <= flag_d;
      irq_q  <= flag_d && en_d;
    end
  end

  // R6: an enabled match sets the flag at the next edge
  p_match_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (en_q && cnt_lo == cmp_q) |=> flag_q);

  // R7: no rise of the flag without an enabled match
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !(en_q && cnt_lo == cmp_q)) |=> !flag_q);

  // R8: flag holds unless a one is written to the clear bit
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(ctl_we && ctl_clr_wr)) |=> flag_q);

  // R8: a clear with no simultaneous match drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_clr_wr && !(en_q && cnt_lo == cmp_q)) |=> !flag_q);

  // R9: a match beats a clear on the same edge
  p_match_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_clr_wr && en_q && cnt_lo == cmp_q) |=> flag_q);

  // R10: the interrupt level tracks flag AND enable
  p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q && en_q));
endmodule

// File: rtl/stc_regfile.sv
module stc_regfile
  import stc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] cmp_q,
  input  logic              en_q,
  input  logic              flag_q,
  output logic              cmp_we,
  output logic              ctl_we,
  output logic              ctl_en_wr,
  output logic              ctl_clr_wr,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_CTRL))   sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFS_CNT_LO)) sel = SEL_CNT_LO;
    else if (bus_addr == ADDR_W'(OFS_CNT_HI)) sel = SEL_CNT_HI;
    else if (bus_addr == ADDR_W'(OFS_CMP))    sel = SEL_CMP;
    else                                      sel = SEL_NONE;
  end

  always_comb begin
    cmp_we     = bus_wr && (sel == SEL_CMP);
    ctl_we     = bus_wr && (sel == SEL_CTRL);
    ctl_en_wr  = bus_wdata[ENA_POS];
    ctl_clr_wr = bus_wdata[FLAG_POS];
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[FLAG_POS] = flag_q;
    ctrl_word[ENA_POS]  = en_q;
    case (sel)
      SEL_CTRL:   rd_mux = ctrl_word;
      SEL_CNT_LO: rd_mux = count[DATA_W-1:0];
      SEL_CNT_HI: rd_mux = DATA_W'(count >> DATA_W);
      SEL_CMP:    rd_mux = cmp_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign rdata = rdata_q;

  // R11: bus idle returns zero data
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> rdata_q == '0);

  // R11: unmapped offsets read zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_NONE) |=> rdata_q == '0);

  // R5: unused status bits never appear in read data
  p_ctrl_unused_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_CTRL) |=>
      (rdata_q & ~((DATA_W'(1) << FLAG_POS) | (DATA_W'(1) << ENA_POS))) == '0);

  // R1: read data is zero during reset
  always_ff @(posedge clk) begin
    if ($past(rst)) p_reset_rdata_r1: assert (rdata_q == '0);
  end
endmodule

// File: rtl/stc_tick_timer.sv
module stc_tick_timer
  import stc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned DATA_W = WORD_W;

  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] cmp_q;
  logic              en_q;
  logic              flag_q;
  logic              cmp_we;
  logic              ctl_we;
  logic              ctl_en_wr;
  logic              ctl_clr_wr;

  stc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .count (count)
  );

  stc_compare #(.DATA_W(DATA_W)) u_compare (
    .clk        (clk),
    .rst        (rst),
    .cnt_lo     (count[DATA_W-1:0]),
    .cmp_we     (cmp_we),
    .cmp_wdata  (bus_wdata),
    .ctl_we     (ctl_we),
    .ctl_en_wr  (ctl_en_wr),
    .ctl_clr_wr (ctl_clr_wr),
    .cmp_q      (cmp_q),
    .en_q       (en_q),
    .flag_q     (flag_q),
    .irq_q      (irq)
  );

  stc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regfile (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .count      (count),
    .cmp_q      (cmp_q),
    .en_q       (en_q),
    .flag_q     (flag_q),
    .cmp_we     (cmp_we),
    .ctl_we     (ctl_we),
    .ctl_en_wr  (ctl_en_wr),
    .ctl_clr_wr (ctl_clr_wr),
    .rdata      (bus_rdata)
  );

  // R1: interrupt low while in reset
  always_ff @(posedge clk) begin
    if ($past(rst)) p_reset_irq_r1: assert (!irq);
  end
endmodule

// File: tb/test_stc_tick_timer.sv
`timescale 1ns/1ps
module test_stc_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int unsigned checks = 0;
  int unsigned errs   = 0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;

  stc_tick_timer i_stc_tick_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural model built from the requirements
  logic [63:0] m_cnt;
  logic [31:0] m_cmp;
  logic        m_en, m_flag, m_hit, m_clr;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_cmp <= '0; m_en <= 1'b0; m_flag <= 1'b0;
    end else begin
      m_hit = m_en && (m_cnt[31:0] == m_cmp);
      m_clr = bus_wr && bus_addr == 6'h00 && bus_wdata[0];
      m_cnt <= m_cnt + 64'd1;
      if (bus_wr && bus_addr == 6'h0C) m_cmp <= bus_wdata;
      if (bus_wr && bus_addr == 6'h00) m_en <= bus_wdata[4];
      m_flag <= m_hit || (m_flag && !m_clr);
    end
  end

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    case (a)
      6'h00:   return {27'd0, m_en, 3'd0, m_flag};
      6'h04:   return m_cnt[31:0];
      6'h08:   return m_cnt[63:32];
      6'h0C:   return m_cmp;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks are entered and left on a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic rd_model(input string req, input logic [5:0] a);
    logic [31:0] e;
    e = exp_read(a);
    rd_chk(req, a, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R10: interrupt level compared every cycle
  always @(negedge clk) begin
    if (!rst && !done) chk("R10 irq", {31'd0, irq}, {31'd0, m_en && m_flag});
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] tgt;
    int unsigned seed;
    seed = $urandom(32'h1D2C3B4A);
    repeat (4) @(negedge clk);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    chk("R1 rdata in reset", bus_rdata, 32'd0);
    rst = 1'b0;

    // R1 reset state
    rd_chk("R1 ctrl", 6'h00, 32'h0);
    rd_chk("R1 cmp", 6'h0C, 32'h0);
    rd_chk("R1 hi", 6'h08, 32'h0);

    // R2 counting
    rd_model("R2 lo", 6'h04);
    idle(7);
    rd_model("R2 lo later", 6'h04);
    rd_model("R2 hi", 6'h08);

    // R3 counter writes ignored
    wr(6'h04, 32'hDEAD_BEEF);
    wr(6'h08, 32'h1234_5678);
    rd_model("R3 lo after write", 6'h04);
    rd_chk("R3 hi after write", 6'h08, 32'h0);

    // R4 compare storage
    wr(6'h0C, 32'hA5A5_5A5A);
    rd_chk("R4 cmp", 6'h0C, 32'hA5A5_5A5A);

    // R5 enable bit and unused status bits
    wr(6'h00, 32'hFFFF_FFEE);
    rd_chk("R5 ctrl enable off", 6'h00, 32'h0);
    wr(6'h00, 32'hFFFF_FFF0);
    rd_chk("R5 ctrl enable on", 6'h00, 32'h10);
    wr(6'h00, 32'h0);

    // R7 no match while disabled
    wr(6'h0C, m_cnt[31:0] + 32'd8);
    idle(20);
    rd_chk("R7 flag stays clear", 6'h00, 32'h0);

    // R6 enabled match
    wr(6'h0C, m_cnt[31:0] + 32'd12);
    wr(6'h00, 32'h10);
    idle(20);
    rd_chk("R6 flag set", 6'h00, 32'h11);
    chk("R6 irq high", {31'd0, irq}, 32'd1);

    // R8 sticky flag and write-one-to-clear
    wr(6'h00, 32'h10);
    rd_chk("R8 write zero keeps flag", 6'h00, 32'h11);
    wr(6'h00, 32'h00);
    rd_chk("R8 flag survives disable", 6'h00, 32'h01);
    chk("R10 irq low when disabled", {31'd0, irq}, 32'd0);
    wr(6'h00, 32'h01);
    rd_chk("R8 clear", 6'h00, 32'h00);

    // R9 match and clear on the same edge
    wr(6'h0C, m_cnt[31:0] + 32'd6);
    wr(6'h00, 32'h10);
    idle(10);
    tgt = m_cnt[31:0] + 32'd10;
    wr(6'h0C, tgt);
    while (m_cnt[31:0] != tgt) @(negedge clk);
    wr(6'h00, 32'h11);
    rd_chk("R9 match beats clear", 6'h00, 32'h11);
    wr(6'h00, 32'h01);
    rd_chk("R8 disable and clear together", 6'h00, 32'h00);

    // R11 unmapped offsets
    rd_chk("R11 offset 0x10", 6'h10, 32'h0);
    rd_chk("R11 offset 0x3C", 6'h3C, 32'h0);
    rd_chk("R11 offset 0x02", 6'h02, 32'h0);
    idle(1);
    chk("R11 idle rdata", bus_rdata, 32'h0);

    // Random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom % 6;
      case (op)
        0: wr(6'h0C, m_cnt[31:0] + ($urandom % 16));
        1: wr(6'h00, {$urandom} & 32'hFFFF_FFFF);
        2: wr(6'($urandom % 64), $urandom);
        3: rd_model("R2 R4 R5 R6 R8 random read", 6'($urandom % 16));
        4: rd_model("R11 random read", 6'($urandom % 64));
        default: idle(1 + ($urandom % 8));
      endcase
    end
    rd_model("R2 final lo", 6'h04);
    rd_model("R6 final ctrl", 6'h00);
    finish_run();
  end
endmodule